// File: doc/BRIEF.md
# Flash Write/Erase Permission Controller

This block decides whether a flash program or page-erase request may go ahead. A register interface writes a page-select register and, through the same address, a sticky sector-protect register. Every request carries a row address, an operation type (program or erase), a target area (main array or information area) and a source tag (CPU or in-circuit programming port). One cycle after each request the block raises either `accept_o` or `ignore_o`.

The page-select register holds an area bit (bit 7: 0 = main array, 1 = information area) and a 7-bit page number (bits 6:0). The protect register holds one bit per 4 KB sector of the 32 KB main array. Protect bits can only be set. A write to the shared address reaches the protect register only when it follows a control write of the key value 0x5E made in the locked state. After one such write the shared address returns to the page-select register.

The request address port carries byte-address bits 15:6. Bits 5:0 select a byte within a 64-byte row and play no part in the decision.

Top module: `flash_guard`

## Requirements
- R1: After reset, `page_sel_o` and `protect_o` are 0x00 and neither `accept_o` nor `ignore_o` is high.
- R2: A cycle with `req_valid_i` high is followed one cycle later by exactly one of `accept_o` / `ignore_o`. A cycle without a request is followed by neither.
- R3: A shared-address write (`sel_wr_i`) in the locked state stores `wdata_i` into page-select: bit 7 is the area bit and bits 6:0 are the page.
- R4: A control write (`ctl_wr_i`) of 0x5E in the locked state arms the protect path. The next shared-address write ORs `wdata_i` into `protect_o`, leaves `page_sel_o` unchanged and returns to the locked state. A control write of any other value does not arm. Any control write while armed disarms.
- R5: A protect bit that is 1 never returns to 0 before reset, whatever is written.
- R6: A main-array request is accepted only if page-select bit 7 is 0 and `req_addr_i[9:3]` (byte address 15:9) equals page-select bits 6:0.
- R7: A CPU main-array request is ignored when the protect bit indexed by `req_addr_i[8:6]` (byte address 14:12) is set.
- R8: A programming-port main-array request disregards the protect bits.
- R9: Every CPU information-area request, whether program or erase, is ignored.
- R10: A programming-port information-area erase is accepted only when page-select equals 0x83 (area bit set, page 3).
- R11: A programming-port information-area program needs page-select equal to 0x83 and also `req_addr_i[6:0]` (byte address 12:6) equal to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_wr_i | input | 1 | Write strobe for the control register |
| sel_wr_i | input | 1 | Write strobe for the shared page-select / protect address |
| wdata_i | input | 8 | Register write data |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | 10 | Byte address bits 15:6 of the request |
| req_erase_i | input | 1 | 1 = page erase, 0 = program |
| req_info_i | input | 1 | 1 = information area, 0 = main array |
| req_dbg_i | input | 1 | 1 = programming port, 0 = CPU |
| accept_o | output | 1 | One-cycle pulse: request may proceed |
| ignore_o | output | 1 | One-cycle pulse: request is dropped |
| page_sel_o | output | 8 | Current page-select value |
| protect_o | output | 8 | Current sector-protect bits |

## Verification
A wrong register value shows up directly on `page_sel_o` or `protect_o` on the cycle after the write. It also flips the decision for whole groups of requests: a wrong page number turns every matching-page request in the next sweep from accept to ignore, and a lost protect bit lets CPU requests to that sector through. A stuck armed state shows up on the next shared-address write, which lands in the protect bits instead of page-select. The bench replays a request sweep over many rows after each register state and compares every pulse one cycle after its request.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  typedef enum logic {
    PATH_PAGE = 1'b0,
    PATH_PROT = 1'b1
  } path_e;
endpackage

// File: rtl/fg_regs.sv
module fg_regs
  import flash_guard_pkg::*;
#(
  parameter int PAGE_W = 7,
  parameter int SECT_N = 8,
  parameter logic [PAGE_W:0] KEY = 8'h5E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic              sel_wr_i,
  input  logic [PAGE_W:0]   wdata_i,
  output logic              info_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [SECT_N-1:0] prot_o
);
  path_e             path_q;
  logic              info_q;
  logic [PAGE_W-1:0] page_q;

  // Only the locked state can arm; any control write from armed disarms.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      path_q <= PATH_PAGE;
    end else if (ctl_wr_i) begin
      path_q <= (path_q == PATH_PAGE && wdata_i == KEY) ? PATH_PROT : PATH_PAGE;
    end else if (sel_wr_i) begin
      path_q <= PATH_PAGE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      info_q <= 1'b0;
      page_q <= '0;
    end else if (sel_wr_i && path_q == PATH_PAGE) begin
      {info_q, page_q} <= wdata_i;
    end
  end

  for (genvar i = 0; i < SECT_N; i++) begin : g_sect
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else if (sel_wr_i && path_q == PATH_PROT && wdata_i[i]) bit_q <= 1'b1;
    end
    assign prot_o[i] = bit_q;
  end

  assign info_o = info_q;
  assign page_o = page_q;

  assert_prot_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(prot_o) & ~prot_o) == '0);

  assert_prot_write_keeps_page_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (path_q == PATH_PROT && sel_wr_i && !ctl_wr_i) |=>
      (path_q == PATH_PAGE && $stable({info_o, page_o})));

  assert_page_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (path_q == PATH_PAGE && sel_wr_i) |=> ({info_o, page_o} == $past(wdata_i)));
endmodule

// File: rtl/fg_rules.sv
module fg_rules #(
  parameter int ADDR_W    = 16,
  parameter int ROW_LSB   = 6,
  parameter int PAGE_W    = 7,
  parameter int SECT_N    = 8,
  parameter int INFO_PAGE = 3
) (
  input  logic                      info_q_i,
  input  logic [PAGE_W-1:0]         page_q_i,
  input  logic [SECT_N-1:0]         prot_q_i,
  input  logic [ADDR_W-ROW_LSB-1:0] addr_i,
  input  logic                      erase_i,
  input  logic                      info_i,
  input  logic                      dbg_i,
  output logic                      allow_o
);
  localparam int ROW_W    = ADDR_W - ROW_LSB;
  localparam int SECT_W   = $clog2(SECT_N);
  // Main array spans ADDR_W-1 bits; sectors are its top SECT_W bits.
  localparam int SECT_LSB = ADDR_W - 1 - SECT_W - ROW_LSB;

  logic [PAGE_W-1:0] addr_page;
  logic [PAGE_W-1:0] addr_info_row;
  logic [SECT_W-1:0] addr_sect;
  logic              page_hit, info_page_ok, sect_locked;

  assign addr_page     = addr_i[ROW_W-1 -: PAGE_W];
  assign addr_info_row = addr_i[PAGE_W-1:0];
  assign addr_sect     = addr_i[SECT_LSB +: SECT_W];

  assign page_hit     = !info_q_i && (addr_page == page_q_i);
  assign info_page_ok = info_q_i && (page_q_i == PAGE_W'(INFO_PAGE));
  assign sect_locked  = prot_q_i[addr_sect];

  always_comb begin
    if (info_i) begin
      allow_o = dbg_i && info_page_ok && (erase_i || addr_info_row == page_q_i);
    end else begin
      allow_o = page_hit && (dbg_i || !sect_locked);
    end
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int ADDR_W    = 16,
  parameter int ROW_LSB   = 6,
  parameter int PAGE_W    = 7,
  parameter int SECT_N    = 8,
  parameter int INFO_PAGE = 3,
  parameter logic [PAGE_W:0] KEY = 8'h5E,
  localparam int DATA_W   = PAGE_W + 1,
  localparam int ROW_W    = ADDR_W - ROW_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic              sel_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              req_valid_i,
  input  logic [ROW_W-1:0]  req_addr_i,
  input  logic              req_erase_i,
  input  logic              req_info_i,
  input  logic              req_dbg_i,
  output logic              accept_o,
  output logic              ignore_o,
  output logic [DATA_W-1:0] page_sel_o,
  output logic [SECT_N-1:0] protect_o
);
  localparam int SECT_W   = $clog2(SECT_N);
  localparam int SECT_LSB = ADDR_W - 1 - SECT_W - ROW_LSB;

  logic              info_q;
  logic [PAGE_W-1:0] page_q;
  logic [SECT_N-1:0] prot_q;
  logic              allow;
  logic              accept_q, ignore_q;

  fg_regs #(.PAGE_W(PAGE_W), .SECT_N(SECT_N), .KEY(KEY)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl_wr_i (ctl_wr_i),
    .sel_wr_i (sel_wr_i),
    .wdata_i  (wdata_i),
    .info_o   (info_q),
    .page_o   (page_q),
    .prot_o   (prot_q)
  );

  fg_rules #(
    .ADDR_W(ADDR_W), .ROW_LSB(ROW_LSB), .PAGE_W(PAGE_W),
    .SECT_N(SECT_N), .INFO_PAGE(INFO_PAGE)
  ) u_rules (
    .info_q_i (info_q),
    .page_q_i (page_q),
    .prot_q_i (prot_q),
    .addr_i   (req_addr_i),
    .erase_i  (req_erase_i),
    .info_i   (req_info_i),
    .dbg_i    (req_dbg_i),
    .allow_o  (allow)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_q <= 1'b0;
      ignore_q <= 1'b0;
    end else begin
      accept_q <= req_valid_i && allow;
      ignore_q <= req_valid_i && !allow;
    end
  end

  assign accept_o   = accept_q;
  assign ignore_o   = ignore_q;
  assign page_sel_o = {info_q, page_q};
  assign protect_o  = prot_q;

  assert_one_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (accept_o != ignore_o));

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!accept_o && !ignore_o));

  assert_cpu_info_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_info_i && !req_dbg_i) |=> ignore_o);

  assert_cpu_prot_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_info_i && !req_dbg_i && protect_o[req_addr_i[SECT_LSB +: SECT_W]])
      |=> ignore_o);

  assert_main_page_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_info_i && page_sel_o[PAGE_W]) |=> ignore_o);
endmodule

// File: tb/flash_guard_bench.sv
module flash_guard_bench;
  localparam time CLK_P = 4ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0, sel_wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       req_valid = 1'b0;
  logic [9:0] req_addr = '0;
  logic       req_erase = 1'b0, req_info = 1'b0, req_dbg = 1'b0;
  logic       accept, ignore;
  logic [7:0] page_sel, protect;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_page = 8'h00;
  logic [7:0] m_prot = 8'h00;

  always #(CLK_P/2) clk = ~clk;

  flash_guard u_flash_guard (
    .clk_i(clk), .rst_ni(rst_n), .ctl_wr_i(ctl_wr), .sel_wr_i(sel_wr),
    .wdata_i(wdata), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_erase_i(req_erase), .req_info_i(req_info), .req_dbg_i(req_dbg),
    .accept_o(accept), .ignore_o(ignore), .page_sel_o(page_sel), .protect_o(protect)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ctl_write(logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic sel_write(logic [7:0] v);
    @(negedge clk); sel_wr = 1'b1; wdata = v;
    @(negedge clk); sel_wr = 1'b0;
  endtask

  function automatic bit model(logic [7:0] pg, logic [7:0] pr, logic [9:0] a,
                               bit er, bit inf, bit dbg);
    if (inf) begin
      if (!dbg) return 1'b0;
      if (pg != 8'h83) return 1'b0;
      if (!er && a[6:0] != 7'd3) return 1'b0;
      return 1'b1;
    end
    if (pg[7]) return 1'b0;
    if (a[9:3] != pg[6:0]) return 1'b0;
    if (!dbg && pr[a[8:6]]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic do_req(logic [9:0] a, bit er, bit inf, bit dbg);
    bit exp;
    string tag;
    exp = model(m_page, m_prot, a, er, inf, dbg);
    if (inf && !dbg) tag = "R9";
    else if (inf && er) tag = "R10";
    else if (inf) tag = "R11";
    else if (dbg) tag = "R8";
    else if (m_page[7] || a[9:3] != m_page[6:0]) tag = "R6";
    else tag = "R7";
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_erase = er; req_info = inf; req_dbg = dbg;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, {30'd0, accept, ignore}, {30'd0, exp, !exp});
  endtask

  task automatic sweep();
    for (int r = 0; r < 1024; r += 3)
      for (int k = 0; k < 8; k++)
        do_req(r[9:0], k[0], k[1], k[2]);
    @(negedge clk);
    check("R2 idle", {30'd0, accept, ignore}, 32'd0);
  endtask

  initial begin
    #(CLK_P * 300000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 page", {24'd0, page_sel}, 32'h00);
    check("R1 prot", {24'd0, protect}, 32'h00);
    check("R1 pulse", {30'd0, accept, ignore}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pulse after release", {30'd0, accept, ignore}, 32'd0);

    // R3 page-select writes
    for (int v = 0; v < 256; v += 37) begin
      sel_write(v[7:0]);
      check("R3", {24'd0, page_sel}, {24'd0, v[7:0]});
      check("R3 prot untouched", {24'd0, protect}, 32'h00);
    end

    // R4 arm, one protect write, then back to page-select
    sel_write(8'h11); m_page = 8'h11;
    ctl_write(8'h5E);
    sel_write(8'h05); m_prot = 8'h05;
    check("R4 prot", {24'd0, protect}, 32'h05);
    check("R4 page kept", {24'd0, page_sel}, 32'h11);
    sel_write(8'h22); m_page = 8'h22;
    check("R4 path returned", {24'd0, page_sel}, 32'h22);
    check("R4 prot kept", {24'd0, protect}, 32'h05);
    ctl_write(8'h5D);
    sel_write(8'h30); m_page = 8'h30;
    check("R4 wrong key", {24'd0, page_sel}, 32'h30);
    check("R4 wrong key prot", {24'd0, protect}, 32'h05);
    ctl_write(8'h5E);
    ctl_write(8'h5E);
    sel_write(8'h40); m_page = 8'h40;
    check("R4 disarm", {24'd0, page_sel}, 32'h40);
    check("R4 disarm prot", {24'd0, protect}, 32'h05);

    // R5 sticky bits
    ctl_write(8'h5E);
    sel_write(8'h00);
    check("R5 zero write", {24'd0, protect}, 32'h05);
    ctl_write(8'h5E);
    sel_write(8'h0A); m_prot = 8'h0F;
    check("R5 or", {24'd0, protect}, 32'h0F);
    check("R5 page kept", {24'd0, page_sel}, 32'h40);

    // R6..R11 request sweeps over several page-select values
    sel_write(8'h00); m_page = 8'h00; sweep();
    sel_write(8'h05); m_page = 8'h05; sweep();
    sel_write(8'h4A); m_page = 8'h4A; sweep();
    sel_write(8'h83); m_page = 8'h83; sweep();
    sel_write(8'h81); m_page = 8'h81; sweep();
    sel_write(8'h03); m_page = 8'h03; sweep();

    ctl_write(8'h5E);
    sel_write(8'hF0); m_prot = 8'hFF;
    check("R5 all set", {24'd0, protect}, 32'hFF);
    sel_write(8'h07); m_page = 8'h07; sweep();
    sel_write(8'h83); m_page = 8'h83; sweep();
    // targeted R11 rows
    do_req(10'h003, 1'b0, 1'b1, 1'b1);
    do_req(10'h083, 1'b0, 1'b1, 1'b1);
    do_req(10'h004, 1'b0, 1'b1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule